// File: doc/BRIEF.md
# Delayed-Sample Button Debouncer

This block conditions a single mechanical push-button whose contact pulls the line low when pressed. The raw input is first brought into the clock domain by a short synchronizer chain. A high-to-low transition of the synchronized level starts a one-shot countdown of roughly 20 ms. When the countdown runs out, the block looks at the button exactly once. If the button is still held at that moment, it raises a sticky "pressed" flag. If the button has let go by then, the event is dropped.

Software or a downstream state machine reads the flag and acknowledges it with a one-cycle clear pulse. The clear only takes effect once the button has been let go. While the flag is already set, further presses are not counted. A toggle output inverts once for every press that the block accepts, so it can drive an indicator LED directly. Contact bounce that arrives while the countdown is running cannot restart it. This means the confirming sample always falls a fixed time after the first edge.

Top module: `press_qualifier`

## Requirements
- R1: During and right after a synchronous reset, flag_o and toggle_o are both 0.
- R2: With btn_n_i low before clock edge e0 and held low, flag_o becomes 1 after edge e0+DLY+3, where DLY is the delay in cycles.
- R3: If btn_n_i is back high when the countdown expires, flag_o does not change and toggle_o does not change.
- R4: Falling edges that arrive while the countdown runs do not restart it, so a bounced press is sampled at the same edge as a clean press that starts at the first edge.
- R5: A clear pulse on clr_i is ignored while the synchronized button level is low (pressed), and flag_o stays 1.
- R6: A clear pulse on clr_i while the synchronized level is high (released) drives flag_o to 0 after that clock edge.
- R7: toggle_o inverts exactly once for each 0-to-1 transition of flag_o, one clock edge after flag_o rises, and at no other time.
- R8: A press that is confirmed while flag_o is already 1 leaves flag_o at 1 and leaves toggle_o unchanged.
- R9: The delay in cycles is DLY = CLK_HZ*DELAY_MS/1000. flag_o is still 0 after edge e0+DLY+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| btn_n_i | input | 1 | Raw button level, low when pressed |
| clr_i | input | 1 | One-cycle acknowledge that clears the pressed flag |
| flag_o | output | 1 | Sticky pressed flag, registered |
| toggle_o | output | 1 | Inverts once per accepted press, registered |

## Verification
The bench builds the block with CLK_HZ=1000 and DELAY_MS=20, which gives a 20-cycle countdown. With this setting, the exact expiry edge, the bounce window inside the countdown and the release-before-expiry case can all be hit cycle by cycle. Every clock, a behavioural model compares flag_o and toggle_o with its own prediction. The model is built from a delay queue on the button and an integer countdown. Directed checks pin the latency boundary on both sides and cover clear attempts during and after a hold.

// File: rtl/pq_pkg.sv
package pq_pkg;

  typedef enum logic {
    TMR_IDLE = 1'b0,
    TMR_RUN  = 1'b1
  } tmr_state_e;

  // cycles of the confirming delay for a clock in Hz and a delay in ms
  function automatic longint unsigned delay_cycles(input longint unsigned hz,
                                                   input longint unsigned ms);
    return (hz * ms) / 1000;
  endfunction

endpackage

// File: rtl/pq_sync_edge.sv
module pq_sync_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic btn_n_i,
  output logic lvl_o,
  output logic fall_o
);

  logic [SYNC_STAGES-1:0] chain_q;
  logic                   prev_q;

  // idle level of the button is high, so every stage resets to 1
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[SYNC_STAGES-2:0], btn_n_i};
      prev_q  <= chain_q[SYNC_STAGES-1];
    end
  end

  assign lvl_o  = chain_q[SYNC_STAGES-1];
  assign fall_o = prev_q & ~chain_q[SYNC_STAGES-1];

endmodule

// File: rtl/pq_oneshot.sv
module pq_oneshot #(
  parameter int unsigned CYCLES = 20,
  parameter int unsigned CW     = 5
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          arm_i,
  output logic          busy_o,
  output logic          fire_o,
  output logic [CW-1:0] left_o
);

  import pq_pkg::*;

  localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

  tmr_state_e    st_q;
  logic [CW-1:0] left_q;
  logic          fire_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      st_q   <= TMR_IDLE;
      left_q <= '0;
      fire_q <= 1'b0;
    end else begin
      unique case (st_q)
        TMR_IDLE: begin
          // arming drops any stale expiry indication
          fire_q <= 1'b0;
          if (arm_i) begin
            st_q   <= TMR_RUN;
            left_q <= LOAD;
          end
        end
        TMR_RUN: begin
          // arm_i is not looked at here: bounce cannot restart the count
          if (left_q == '0) begin
            st_q   <= TMR_IDLE;
            fire_q <= 1'b1;
          end else begin
            left_q <= left_q - 1'b1;
            fire_q <= 1'b0;
          end
        end
        default: st_q <= TMR_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q == TMR_RUN);
  assign fire_o = fire_q;
  assign left_o = left_q;

endmodule

// File: rtl/pq_latch_toggle.sv
module pq_latch_toggle (
  input  logic clk_i,
  input  logic rst_i,
  input  logic fire_i,
  input  logic lvl_i,
  input  logic clr_i,
  output logic flag_o,
  output logic toggle_o
);

  logic flag_q;
  logic set_pulse_q;
  logic toggle_q;
  logic accept;
  logic clr_ok;

  assign accept = fire_i & ~lvl_i;
  assign clr_ok = clr_i & lvl_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      flag_q      <= 1'b0;
      set_pulse_q <= 1'b0;
      toggle_q    <= 1'b0;
    end else begin
      if (accept)      flag_q <= 1'b1;
      else if (clr_ok) flag_q <= 1'b0;
      set_pulse_q <= accept & ~flag_q;
      toggle_q    <= toggle_q ^ set_pulse_q;
    end
  end

  assign flag_o   = flag_q;
  assign toggle_o = toggle_q;

endmodule

// File: rtl/press_qualifier.sv
module press_qualifier #(
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned DELAY_MS    = 20,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic btn_n_i,
  input  logic clr_i,
  output logic flag_o,
  output logic toggle_o
);

  localparam int unsigned DLY_CYC =
    32'(pq_pkg::delay_cycles(64'(CLK_HZ), 64'(DELAY_MS)));
  localparam int unsigned CW = (DLY_CYC > 1) ? $clog2(DLY_CYC) : 1;

  logic          btn_lvl;
  logic          btn_fall;
  logic          tmr_busy;
  logic          tmr_fire;
  logic [CW-1:0] tmr_left;

  pq_sync_edge #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .btn_n_i(btn_n_i),
    .lvl_o  (btn_lvl),
    .fall_o (btn_fall)
  );

  pq_oneshot #(
    .CYCLES(DLY_CYC),
    .CW    (CW)
  ) u_tmr (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .arm_i (btn_fall),
    .busy_o(tmr_busy),
    .fire_o(tmr_fire),
    .left_o(tmr_left)
  );

  pq_latch_toggle u_flag (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .fire_i  (tmr_fire),
    .lvl_i   (btn_lvl),
    .clr_i   (clr_i),
    .flag_o  (flag_o),
    .toggle_o(toggle_o)
  );

endmodule

// File: rtl/press_qualifier_chk.sv
module press_qualifier_chk #(
  parameter int unsigned CW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          lvl,
  input logic          fall,
  input logic          busy,
  input logic          fire,
  input logic [CW-1:0] left,
  input logic          clr,
  input logic          flag,
  input logic          toggle
);

  AST_SET_NEEDS_EXPIRY: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(fire)); // R2

  AST_SET_NEEDS_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> !$past(lvl)); // R3

  AST_RUN_NOT_RESTARTED: assert property (@(posedge clk) disable iff (rst)
    (busy && left != '0) |=> (busy && left == $past(left) - 1'b1)); // R4

  AST_IDLE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
    (!busy && !fall) |=> !busy); // R4

  AST_CLR_BLOCKED_PRESSED: assert property (@(posedge clk) disable iff (rst)
    (clr && !lvl && flag) |=> flag); // R5

  AST_CLR_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (clr && lvl) |=> !flag); // R6

  AST_TOGGLE_AFTER_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |=> (toggle != $past(toggle))); // R7

  AST_TOGGLE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (toggle != $past(toggle)) |-> ($past(flag) && !$past(flag, 2))); // R7

endmodule

bind press_qualifier press_qualifier_chk #(.CW(CW)) u_chk (
  .clk   (clk_i),
  .rst   (rst_i),
  .lvl   (btn_lvl),
  .fall  (btn_fall),
  .busy  (tmr_busy),
  .fire  (tmr_fire),
  .left  (tmr_left),
  .clr   (clr_i),
  .flag  (flag_o),
  .toggle(toggle_o)
);

// File: tb/tb_press_qualifier.sv
module tb_press_qualifier;

  localparam int TB_HZ = 1000;
  localparam int TB_MS = 20;
  localparam int D     = TB_HZ * TB_MS / 1000;

  logic clk = 1'b0;
  logic rst;
  logic btn;
  logic clr;
  logic flag;
  logic tog;

  int checks   = 0;
  int failures = 0;

  always #10 clk = ~clk;

  press_qualifier #(
    .CLK_HZ  (TB_HZ),
    .DELAY_MS(TB_MS)
  ) dut (
    .clk_i   (clk),
    .rst_i   (rst),
    .btn_n_i (btn),
    .clr_i   (clr),
    .flag_o  (flag),
    .toggle_o(tog)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // behavioural reference: button seen through a two-edge delay queue
  bit hq[$];
  bit m_flag, m_tog, m_pulse, m_run, m_fire;
  int m_left;
  bit lv, pv, fall, nflag, npulse;

  always @(posedge clk) begin
    if (rst) begin
      hq = '{1'b1, 1'b1, 1'b1};
      m_flag = 0; m_tog = 0; m_pulse = 0; m_run = 0; m_fire = 0; m_left = 0;
    end else begin
      lv   = hq[1];
      pv   = hq[2];
      fall = pv && !lv;
      if (m_fire && !lv)   nflag = 1'b1;
      else if (clr && lv)  nflag = 1'b0;
      else                 nflag = m_flag;
      npulse  = m_fire && !lv && !m_flag;
      m_tog   = m_tog ^ m_pulse;
      m_pulse = npulse;
      m_flag  = nflag;
      if (!m_run) begin
        m_fire = 0;
        if (fall) begin
          m_run  = 1;
          m_left = D - 1;
        end
      end else if (m_left == 0) begin
        m_run  = 0;
        m_fire = 1;
      end else begin
        m_left--;
        m_fire = 0;
      end
      hq.push_front(btn);
      void'(hq.pop_back());
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check("R2 model flag", flag, m_flag);
      check("R7 model toggle", tog, m_tog);
    end
  end

  task automatic pulse_clr();
    clr = 1'b1;
    wait_n(1);
    clr = 1'b0;
  endtask

  initial begin
    rst = 1'b1; btn = 1'b1; clr = 1'b0;
    wait_n(4);
    check("R1 flag in reset", flag, 1'b0);
    check("R1 toggle in reset", tog, 1'b0);
    rst = 1'b0;
    wait_n(1);
    check("R1 flag after reset", flag, 1'b0);
    check("R1 toggle after reset", tog, 1'b0);
    wait_n(4);

    // clean press held through expiry
    btn = 1'b0;
    wait_n(D + 3);
    check("R9 no sample before delay", flag, 1'b0);
    wait_n(1);
    check("R2 flag at delay", flag, 1'b1);
    check("R7 toggle lags flag", tog, 1'b0);
    wait_n(1);
    check("R7 toggle after rise", tog, 1'b1);

    // clear while still pressed
    pulse_clr();
    check("R5 clear ignored while pressed", flag, 1'b1);
    wait_n(1);
    check("R5 flag held", flag, 1'b1);

    // release, then clear
    btn = 1'b1;
    wait_n(4);
    pulse_clr();
    check("R6 clear after release", flag, 1'b0);
    check("R6 toggle kept", tog, 1'b1);

    // short press released before expiry
    btn = 1'b0;
    wait_n(5);
    btn = 1'b1;
    wait_n(D + 10);
    check("R3 rejected flag", flag, 1'b0);
    check("R3 rejected toggle", tog, 1'b1);

    // bounced press: extra falling edge inside the countdown
    btn = 1'b0;
    wait_n(3);
    btn = 1'b1;
    wait_n(2);
    btn = 1'b0;
    wait_n(D - 2);
    check("R4 bounce no early sample", flag, 1'b0);
    wait_n(1);
    check("R4 bounce not restarted", flag, 1'b1);
    wait_n(1);
    check("R7 second toggle", tog, 1'b0);

    // press confirmed while flag already set
    btn = 1'b1;
    wait_n(5);
    btn = 1'b0;
    wait_n(D + 10);
    check("R8 flag stays", flag, 1'b1);
    check("R8 toggle unchanged", tog, 1'b0);

    btn = 1'b1;
    wait_n(4);
    pulse_clr();
    check("R6 second clear", flag, 1'b0);

    // third accepted press
    btn = 1'b0;
    wait_n(D + 5);
    check("R2 third flag", flag, 1'b1);
    check("R7 third toggle", tog, 1'b1);
    btn = 1'b1;
    wait_n(10);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2_000_000;
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule